// File: doc/BRIEF.md
# Background Comparator Threshold Learner

This block tracks, entirely in logic, where each comparator of one coarse flash quantizer in a pipelined converter actually switches. For every conversion it gets two inputs. One is the coarse code that the flash stage produced. The other is the fine code that the later stages produced for the same analog sample. The fine code is cut down to a calibration resolution by dropping its low bits. The block holds one signed threshold correction per comparator. It moves a correction by one step whenever the fine value lands outside the window that the coarse code claims.

Each correction is a move does not fit the current windows is reported to a downstream trim-code generator. The report is a one-cycle enable, the index of the comparator whose correction moved, and the new correction value. All corrections are also available together on a packed bus. No dedicated test signal is needed: ordinary conversion traffic is enough for the corrections to converge.

Top module: `ato_estimator`

## Requirements
- R1: While reset is low, and after it is released, every correction is zero and `upd_en` is low.
- R2: The fine value X is the back-end code shifted right by BE_BITS−CAL_BITS and floored. The nominal switching point of comparator j is j·2^(CAL_BITS−STAGE_BITS). For code k, the accepted window is closed, from nominal(k)+corr(k) to nominal(k+1)+corr(k+1). When X lies in the window, nothing changes and `upd_en` stays low.
- R3: When X is strictly above the upper edge of the window for code k, correction k+1 rises by one step. `upd_en` is then 1 and `upd_ptr` is k+1.
- R4: When X is strictly below the lower edge of the window for code k, correction k falls by one step. `upd_en` is then 1 and `upd_ptr` is k.
- R5: For code 0, only the upper-edge test is made. For the top code M = 2^STAGE_BITS−1, only the lower-edge test is made.
- R6: When both edges are violated at once, which happens only if the corrections have crossed, only the upper-edge update of R3 is done.
- R7: A sample presented at rising edge t produces its `upd_en`, `upd_ptr` and `upd_off` after edge t+1. A sample at edge t+1 is judged against the corrections already changed by the sample at edge t.
- R8: When `in_valid` is low at an edge, the code and back-end inputs at that edge change no correction and raise no enable.
- R9: Correction j (1..M) sits in `off_all[j*OW-1 -: OW]` as two's complement in units of 2^−FRAC_BITS fine LSBs, where OW = CAL_BITS+2+FRAC_BITS. `upd_off` equals the new content of the slot named by `upd_ptr`, and only that slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_code | input | STAGE_BITS | Coarse code k of the flash stage |
| in_be | input | BE_BITS | Back-end code of the same sample |
| upd_en | output | 1 | One-cycle update enable for the trim-code generator |
| upd_ptr | output | STAGE_BITS | Index (1..M) of the comparator that moved |
| upd_off | output | OW | New correction of that comparator |
| off_all | output | M*OW | All corrections, comparator j in slot j−1 |

## Verification
The bench aims at the exact window edges. A design with an open interval, or one that rounds the back-end code instead of flooring it, would raise an enable on a value that sits on an edge. The bench drives the two extreme codes. A design that ran both tests there would index a comparator that does not exist, or move the wrong correction. Back-to-back samples on one comparator catch a design that reads stale corrections and overshoots by a step. A long run that deliberately drives two corrections past each other checks the tie-break: a design that lowered the lower correction, or moved both, would show the wrong pointer and bank.

// File: rtl/ato_pkg.sv
// Shared types for the threshold learner.
// Assumes nothing beyond IEEE 1800-2017 enums.
package ato_pkg;

    // Direction in which a selected correction moves.
    typedef enum logic [1:0] {
        ATO_HOLD = 2'd0,
        ATO_UP   = 2'd1,
        ATO_DOWN = 2'd2
    } ato_dir_e;

endpackage

// File: rtl/ato_sample_reg.sv
// Input capture stage: registers the strobe, coarse code and the
// floored fine value. Assumes BE_BITS >= CAL_BITS.
module ato_sample_reg #(
    parameter int STAGE_BITS = 3,
    parameter int CAL_BITS   = 8,
    parameter int BE_BITS    = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [STAGE_BITS-1:0] in_code,
    input  logic [BE_BITS-1:0]    in_be,
    output logic                  smp_valid,
    output logic [STAGE_BITS-1:0] smp_code,
    output logic [CAL_BITS-1:0]   smp_x
);
    localparam int DROP = BE_BITS - CAL_BITS;

    // Capture one sample per cycle; the low back-end bits are floored away.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_code  <= '0;
            smp_x     <= '0;
        end else begin
            smp_valid <= in_valid;
            smp_code  <= in_code;
            smp_x     <= CAL_BITS'(in_be >> DROP);
        end
    end
endmodule

// File: rtl/ato_window_check.sv
// Combinational window test: compares the captured fine value with the
// two corrected switching points around the captured code and picks at
// most one correction to move. Assumes corrections are two's complement
// with FRAC_BITS fractional bits; steps saturate at the signed limits.
module ato_window_check
    import ato_pkg::*;
#(
    parameter int STAGE_BITS = 3,
    parameter int CAL_BITS   = 8,
    parameter int FRAC_BITS  = 0,
    parameter int GUARD_BITS = 2
) (
    input  logic                                         smp_valid,
    input  logic [STAGE_BITS-1:0]                        smp_code,
    input  logic [CAL_BITS-1:0]                          smp_x,
    input  logic [((1<<STAGE_BITS)-1)*(CAL_BITS+GUARD_BITS+FRAC_BITS)-1:0] off_all,
    output logic                                         upd_req,
    output logic [STAGE_BITS-1:0]                        upd_ptr,
    output logic signed [CAL_BITS+GUARD_BITS+FRAC_BITS-1:0] upd_val
);
    localparam int M      = (1 << STAGE_BITS) - 1;
    localparam int OW     = CAL_BITS + GUARD_BITS + FRAC_BITS;
    localparam int CW     = OW + 2;
    localparam int IW     = STAGE_BITS + 1;
    localparam int TSHIFT = CAL_BITS - STAGE_BITS + FRAC_BITS;
    localparam logic signed [OW-1:0] OFF_MAX = {1'b0, {(OW-1){1'b1}}};
    localparam logic signed [OW-1:0] OFF_MIN = {1'b1, {(OW-1){1'b0}}};

    logic signed [OW-1:0] off_arr [0:M+1];
    logic [IW-1:0]        lo_idx, hi_idx;
    logic signed [OW-1:0] off_lo, off_hi;
    logic signed [CW-1:0] x_s, lo_b, hi_b;
    logic                 at_top, at_bot, hi_viol, lo_viol;
    ato_dir_e             dir;

    // Unpack the bank; slots 0 and M+1 are virtual and read as zero.
    always_comb begin
        off_arr[0]   = '0;
        off_arr[M+1] = '0;
        for (int j = 1; j <= M; j++) begin
            off_arr[j] = off_all[j*OW-1 -: OW];
        end
    end

    // Build both corrected edges and the scaled fine value.
    always_comb begin
        lo_idx = {1'b0, smp_code};
        hi_idx = lo_idx + IW'(1);
        off_lo = off_arr[lo_idx];
        off_hi = off_arr[hi_idx];
        x_s    = signed'(CW'(smp_x)) <<< FRAC_BITS;
        lo_b   = signed'(CW'(lo_idx) << TSHIFT) + CW'(off_lo);
        hi_b   = signed'(CW'(hi_idx) << TSHIFT) + CW'(off_hi);
    end

    // Edge tests; extreme codes test only their single inner edge.
    always_comb begin
        at_top  = &smp_code;
        at_bot  = (smp_code == '0);
        hi_viol = smp_valid && !at_top && (x_s > hi_b);
        lo_viol = smp_valid && !at_bot && (x_s < lo_b);
    end

    // Choose one move, upper edge first, and form the saturated value.
    always_comb begin
        dir     = ATO_HOLD;
        upd_ptr = '0;
        upd_val = '0;
        if (hi_viol) begin
            dir     = ATO_UP;
            upd_ptr = hi_idx[STAGE_BITS-1:0];
            upd_val = (off_hi == OFF_MAX) ? off_hi : off_hi + OW'(1);
        end else if (lo_viol) begin
            dir     = ATO_DOWN;
            upd_ptr = smp_code;
            upd_val = (off_lo == OFF_MIN) ? off_lo : off_lo - OW'(1);
        end
        upd_req = (dir != ATO_HOLD);
    end
endmodule

// File: rtl/ato_offset_bank.sv
// Register bank of M corrections, one slot per comparator, written one
// slot at a time. Assumes the write address is 1..M when written.
module ato_offset_bank #(
    parameter int STAGE_BITS = 3,
    parameter int OW         = 10
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [STAGE_BITS-1:0]                 wr_addr,
    input  logic [OW-1:0]                         wr_data,
    output logic [((1<<STAGE_BITS)-1)*OW-1:0]     off_all
);
    localparam int M = (1 << STAGE_BITS) - 1;

    for (genvar j = 1; j <= M; j++) begin : g_slot
        logic [OW-1:0] slot_q;

        // Hold correction j; load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_addr == STAGE_BITS'(j))) begin
                slot_q <= wr_data;
            end
        end

        assign off_all[j*OW-1 -: OW] = slot_q;
    end
endmodule

// File: rtl/ato_estimator.sv
// Top of the threshold learner: input capture, window test, correction
// bank and the registered report to the trim-code generator.
// Assumes one sample per cycle at most and CAL_BITS > STAGE_BITS.
module ato_estimator #(
    parameter int STAGE_BITS = 3,
    parameter int CAL_BITS   = 8,
    parameter int BE_BITS    = 14,
    parameter int FRAC_BITS  = 0,
    parameter int GUARD_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [STAGE_BITS-1:0] in_code,
    input  logic [BE_BITS-1:0]    in_be,
    output logic                  upd_en,
    output logic [STAGE_BITS-1:0] upd_ptr,
    output logic [CAL_BITS+GUARD_BITS+FRAC_BITS-1:0] upd_off,
    output logic [((1<<STAGE_BITS)-1)*(CAL_BITS+GUARD_BITS+FRAC_BITS)-1:0] off_all
);
    localparam int M  = (1 << STAGE_BITS) - 1;
    localparam int OW = CAL_BITS + GUARD_BITS + FRAC_BITS;

    logic                  smp_valid;
    logic [STAGE_BITS-1:0] smp_code;
    logic [CAL_BITS-1:0]   smp_x;
    logic                  req;
    logic [STAGE_BITS-1:0] req_ptr;
    logic signed [OW-1:0]  req_val;
    logic [M*OW-1:0]       bank_q;

    ato_sample_reg #(
        .STAGE_BITS(STAGE_BITS), .CAL_BITS(CAL_BITS), .BE_BITS(BE_BITS)
    ) u_smp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .in_be(in_be), .smp_valid(smp_valid), .smp_code(smp_code), .smp_x(smp_x)
    );

    ato_window_check #(
        .STAGE_BITS(STAGE_BITS), .CAL_BITS(CAL_BITS),
        .FRAC_BITS(FRAC_BITS), .GUARD_BITS(GUARD_BITS)
    ) u_win (
        .smp_valid(smp_valid), .smp_code(smp_code), .smp_x(smp_x),
        .off_all(bank_q), .upd_req(req), .upd_ptr(req_ptr), .upd_val(req_val)
    );

    ato_offset_bank #(
        .STAGE_BITS(STAGE_BITS), .OW(OW)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(req), .wr_addr(req_ptr),
        .wr_data(req_val), .off_all(bank_q)
    );

    // Register the report alongside the bank write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_en  <= 1'b0;
            upd_ptr <= '0;
            upd_off <= '0;
        end else begin
            upd_en <= req;
            if (req) begin
                upd_ptr <= req_ptr;
                upd_off <= req_val;
            end
        end
    end

    assign off_all = bank_q;
endmodule

// File: rtl/ato_estimator_chk.sv
// Property checker for ato_estimator, attached by bind below.
// Assumes the top's default latency of two edges from sample to report.
module ato_estimator_chk #(
    parameter int STAGE_BITS = 3,
    parameter int OW         = 10
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              in_valid,
    input logic [STAGE_BITS-1:0]             in_code,
    input logic                              upd_en,
    input logic [STAGE_BITS-1:0]             upd_ptr,
    input logic [OW-1:0]                     upd_off,
    input logic [((1<<STAGE_BITS)-1)*OW-1:0] off_all
);
    localparam int M = (1 << STAGE_BITS) - 1;

    logic                  v_d1, v_d2;
    logic [STAGE_BITS-1:0] k_d1, k_d2;

    // Delay the strobe and code to line up with the report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_d1 <= 1'b0; v_d2 <= 1'b0; k_d1 <= '0; k_d2 <= '0;
        end else begin
            v_d1 <= in_valid; v_d2 <= v_d1; k_d1 <= in_code; k_d2 <= k_d1;
        end
    end

    AST_EN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> v_d2); // R8
    AST_PTR_NEAR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> ((upd_ptr == k_d2) || ({1'b0, upd_ptr} == {1'b0, k_d2} + (STAGE_BITS+1)'(1)))); // R3
    AST_BOTTOM_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (k_d2 == '0)) |-> (upd_ptr == STAGE_BITS'(1))); // R5
    AST_TOP_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (&k_d2)) |-> (upd_ptr == STAGE_BITS'(M))); // R5

    for (genvar j = 1; j <= M; j++) begin : g_slot
        logic [OW-1:0]        prev_q;
        logic signed [OW:0]   dlt;

        // Keep last cycle's value of slot j.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= off_all[j*OW-1 -: OW];
        end

        assign dlt = signed'({off_all[j*OW-1], off_all[j*OW-1 -: OW]})
                   - signed'({prev_q[OW-1], prev_q});

        AST_ONLY_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
            (off_all[j*OW-1 -: OW] != prev_q) |-> (upd_en && (upd_ptr == STAGE_BITS'(j)))); // R9
        AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && (upd_ptr == STAGE_BITS'(j))) |->
            ((off_all[j*OW-1 -: OW] == upd_off) && ((dlt == 1) || (dlt == -1) || (dlt == 0)))); // R4
    end
endmodule

bind ato_estimator ato_estimator_chk #(
    .STAGE_BITS(STAGE_BITS), .OW(CAL_BITS + GUARD_BITS + FRAC_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .upd_en(upd_en), .upd_ptr(upd_ptr), .upd_off(upd_off), .off_all(off_all)
);

// File: tb/tb_ato_estimator.sv
module tb_ato_estimator;
    localparam int SB   = 3;
    localparam int CAL  = 8;
    localparam int BE   = 14;
    localparam int M    = 7;
    localparam int OW   = 10;
    localparam int DROP = BE - CAL;
    localparam int NOM  = 1 << (CAL - SB);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [SB-1:0]     in_code = '0;
    logic [BE-1:0]     in_be = '0;
    logic              upd_en;
    logic [SB-1:0]     upd_ptr;
    logic [OW-1:0]     upd_off;
    logic [M*OW-1:0]   off_all;

    int n_checks = 0;
    int n_errs   = 0;
    int om [0:M+1];
    bit finished = 0;

    always #5 clk = ~clk;

    ato_estimator dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .in_be(in_be), .upd_en(upd_en), .upd_ptr(upd_ptr), .upd_off(upd_off),
        .off_all(off_all)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int slot(input int j);
        logic signed [OW-1:0] s;
        s = off_all[j*OW-1 -: OW];
        return int'(s);
    endfunction

    task automatic check_bank(input string tag);
        for (int j = 1; j <= M; j++) check(tag, $sformatf("corr[%0d]", j), slot(j), om[j]);
    endtask

    // Reference rule: closed window, upper edge first, extremes single-sided.
    function automatic void model(input int k, input int x, input bit v,
                                  output bit en, output int ptr);
        bit hi, lo;
        en = 0; ptr = 0;
        if (!v) return;
        hi = (k != M) && (x > NOM*(k+1) + om[k+1]);
        lo = (k != 0) && (x < NOM*k + om[k]);
        if (hi) begin om[k+1]++; en = 1; ptr = k+1; end
        else if (lo) begin om[k]--; en = 1; ptr = k; end
    endfunction

    task automatic drive(input int k, input int x, input bit v, input int junk);
        in_valid = v;
        in_code  = SB'(k);
        in_be    = (BE'(x) << DROP) | BE'(junk);
    endtask

    // One isolated sample, report checked after the second edge.
    task automatic send(input string tag, input int k, input int x, input bit v,
                        input int junk, input bit exp_en, input bit full);
        bit men; int mptr;
        model(k, x, v, men, mptr);
        @(negedge clk); drive(k, x, v, junk);
        @(negedge clk); in_valid = 0;
        @(negedge clk);
        check(tag, "upd_en", int'(upd_en), int'(exp_en));
        if (exp_en) begin
            check(tag, "upd_ptr", int'(upd_ptr), mptr);
            check(tag, "upd_off", int'(signed'(upd_off)), om[mptr]);
        end
        if (full) check_bank(tag);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1", "upd_en in reset", int'(upd_en), 0);
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        check("R1", "upd_en", int'(upd_en), 0);
        check_bank("R1");
    endtask

    task automatic t_window();
        send("R2", 3, 100, 1, 0, 0, 1);
        send("R2", 3, 128, 1, 0, 0, 1);   // on the upper edge
        send("R2", 3, 96, 1, 0, 0, 1);    // on the lower edge
        send("R2", 3, 128, 1, 63, 0, 1);  // low bits floored, not rounded
    endtask

    task automatic t_edges();
        send("R3", 2, 100, 1, 0, 1, 1);
        send("R4", 5, 150, 1, 0, 1, 1);
    endtask

    task automatic t_extremes();
        send("R5", 0, 0, 1, 0, 0, 1);
        send("R5", 0, 40, 1, 0, 1, 1);
        send("R5", M, 255, 1, 0, 0, 1);
        send("R5", M, 100, 1, 0, 1, 1);
    endtask

    task automatic t_invalid();
        send("R8", 2, 255, 0, 0, 0, 1);
        send("R8", 5, 0, 0, 0, 0, 1);
    endtask

    task automatic t_back_to_back();
        bit e1, e2; int p1, p2;
        for (int i = 0; i < 6; i++) send("R7", 0, 40, 1, 0, 1, 0);
        check("R7", "corr[1] before pair", slot(1), 7);
        model(0, 40, 1, e1, p1);
        model(0, 40, 1, e2, p2);
        @(negedge clk); drive(0, 40, 1, 0);
        @(negedge clk); drive(0, 40, 1, 0);
        @(negedge clk); in_valid = 0;
        check("R7", "first upd_en", int'(upd_en), 1);
        check("R7", "first upd_ptr", int'(upd_ptr), 1);
        @(negedge clk);
        check("R7", "second upd_en", int'(upd_en), 0);
        check("R7", "corr[1] after pair", slot(1), 8);
        check_bank("R7");
    endtask

    task automatic t_priority();
        for (int i = 0; i < 158; i++) send("R3", 2, 255, 1, 0, 1, 0);
        check("R3", "corr[3] grown", slot(3), 159);
        send("R3", 2, 255, 1, 0, 0, 1);   // now converged on the edge
        send("R6", 3, 140, 1, 0, 1, 1);
        check("R6", "pointer picks upper", int'(upd_ptr), 4);
        check("R6", "corr[4]", slot(4), 1);
        check("R6", "corr[3] untouched", slot(3), 159);
    endtask

    initial begin
        for (int j = 0; j <= M+1; j++) om[j] = 0;
        t_reset();
        t_window();
        t_edges();
        t_extremes();
        t_invalid();
        t_back_to_back();
        t_priority();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule